// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache Lookup

This block holds the tag directory and the data storage of an 8 KB data cache. The cache has two ways, 256 sets and 16-byte lines, and takes 32-bit byte addresses. A processor-side request carries a read or write flag, an address and a 32-bit word. The block compares the tags of both ways of the addressed set at the same time. It answers one cycle later with hit or miss, the way used and the data word.

On a read miss the block picks a victim way. It takes an invalid way first, otherwise the way named by the single LRU bit of the set. It then fetches the whole line from a simple memory port, four words in order. If the victim is Modified, the block first copies it into a one-entry write-back buffer, which drains through a valid/acknowledge port. The block does not decide coherency states. A separate controller writes them through a dedicated port and supplies the state given to each newly filled line.

Top module: `cache2w_lookup`

## Requirements
- R1: Address bits 31:12 are the tag, bits 11:4 the set, and bits 3:2 the word within the line. Bits 1:0 are ignored, so any byte address inside a word reaches that word.
- R2: A read request that matches a non-Invalid way is answered one cycle after acceptance with resp_valid=1, resp_hit=1, resp_way set to the matching way and resp_rdata set to the stored word.
- R3: Two lines with the same set index and different tags stay resident together, one in each way, and both hit.
- R4: Any hit or fill makes the set's LRU bit name the other way. When both ways are valid, a miss replaces the way the LRU bit names.
- R5: When a set has an Invalid way, a miss fills it, preferring way 0 over way 1 and ignoring the LRU bit.
- R6: A read miss holds fill_req with the line-aligned fill_addr. It takes four fill_valid beats as words 0..3 in order. After the last beat it answers with resp_hit=0 and the requested word; with a clean victim this is 5 cycles after acceptance. req_ready stays low while the fill runs.
- R7: A write hit replaces only the addressed word of the line and answers with resp_hit=1 after one cycle. A write miss answers with resp_hit=0 after one cycle and allocates nothing.
- R8: Each way of each set holds a 2-bit state: Invalid=00, Shared=01, Exclusive=10, Modified=11. A line in state 00 never hits. coh_upd writes coh_state into way coh_way of set coh_set. A completed fill installs the line with fill_state.
- R9: A Modified victim is copied into the write-back buffer before its fill starts. wb_addr is the victim's line-aligned address and wb_data holds its four words, with word 0 in bits 31:0. wb_valid, wb_addr and wb_data hold until wb_ack.
- R10: If the write-back buffer is occupied when a Modified victim must leave, fill_req stays low until wb_ack frees the buffer.
- R11: After reset every line is Invalid, every LRU bit is 0, req_ready=1, and resp_valid, fill_req and wb_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Word to write |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| resp_valid | output | 1 | Response present for one cycle |
| resp_hit | output | 1 | Request hit in the cache |
| resp_way | output | 1 | Way hit or filled |
| resp_rdata | output | 32 | Read word (write data on a write hit) |
| fill_req | output | 1 | Line fill requested |
| fill_addr | output | 32 | Line-aligned fill address |
| fill_valid | input | 1 | Fill word present |
| fill_data | input | 32 | Fill word, words 0..3 in order |
| fill_state | input | 2 | State given to the filled line |
| wb_valid | output | 1 | Write-back buffer holds a line |
| wb_addr | output | 32 | Line-aligned address of the buffered line |
| wb_data | output | 128 | Buffered line, word 0 in bits 31:0 |
| wb_ack | input | 1 | Buffered line taken by memory |
| coh_upd | input | 1 | Write a line state |
| coh_set | input | 8 | Set index for the state write |
| coh_way | input | 1 | Way for the state write |
| coh_state | input | 2 | New state |

## Verification
Several properties are checked on every cycle. The fill address must be aligned and must not move while the fill runs. Requests must be refused and no response may appear during a fill. A fill must end in a miss response, every hit response must follow an accepted request by one cycle, and the write-back buffer must hold still until it is acknowledged. Victim choice, LRU aging, word isolation on writes, absence of allocation on write misses and the stall behind a full write-back buffer can only be shown by the bench's sequences of dependent accesses. Those sequences are a table of accesses to one contested set, followed by directed state changes through the coherency port.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'b00,
      LS_SHR = 2'b01,
      LS_EXC = 2'b10,
      LS_MOD = 2'b11
   } line_state_e;

   typedef enum logic [1:0] {
      CS_IDLE  = 2'b00,
      CS_DRAIN = 2'b01,
      CS_FILL  = 2'b10
   } ctl_state_e;

   localparam int unsigned NUM_WAYS = 2;
endpackage

// File: rtl/cache2w_tag_dir.sv
module cache2w_tag_dir
   import cache2w_pkg::*;
#(
   parameter int unsigned SET_W = 8,
   parameter int unsigned TAG_W = 20
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [SET_W-1:0]                     lk_set,
   input  logic [TAG_W-1:0]                     lk_tag,
   output logic [NUM_WAYS-1:0]                  lk_match,
   output logic [NUM_WAYS-1:0][1:0]             lk_state,
   output logic [NUM_WAYS-1:0][TAG_W-1:0]       lk_tagout,
   output logic                                 lk_lru,
   input  logic                                 touch_en,
   input  logic [SET_W-1:0]                     touch_set,
   input  logic                                 touch_way,
   input  logic                                 inst_en,
   input  logic [SET_W-1:0]                     inst_set,
   input  logic                                 inst_way,
   input  logic [TAG_W-1:0]                     inst_tag,
   input  logic [1:0]                           inst_state,
   input  logic                                 coh_en,
   input  logic [SET_W-1:0]                     coh_set,
   input  logic                                 coh_way,
   input  logic [1:0]                           coh_state
);
   localparam int unsigned NSETS = 1 << SET_W;

   logic lru_q [NSETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NSETS; s++) lru_q[s] <= 1'b0;
      end else if (touch_en) begin
         lru_q[touch_set] <= ~touch_way;
      end
   end

   assign lk_lru = lru_q[lk_set];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tag_q [NSETS];
      logic [1:0]       st_q  [NSETS];
      logic             inst_here;
      logic             coh_here;

      assign inst_here = inst_en && (inst_way == 1'(w));
      assign coh_here  = coh_en  && (coh_way  == 1'(w));

      always_ff @(posedge clk) begin
         if (inst_here) tag_q[inst_set] <= inst_tag;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) st_q[s] <= LS_INV;
         end else begin
            if (coh_here)  st_q[coh_set]  <= coh_state;
            if (inst_here) st_q[inst_set] <= inst_state;
         end
      end

      assign lk_state[w]  = st_q[lk_set];
      assign lk_tagout[w] = tag_q[lk_set];
      assign lk_match[w]  = (st_q[lk_set] != LS_INV) && (tag_q[lk_set] == lk_tag);
   end
endmodule

// File: rtl/cache2w_data_ram.sv
module cache2w_data_ram
   import cache2w_pkg::*;
#(
   parameter int unsigned SET_W  = 8,
   parameter int unsigned WSEL_W = 2,
   parameter int unsigned DATA_W = 32
) (
   input  logic                                    clk,
   input  logic [SET_W-1:0]                        rd_set,
   output logic [NUM_WAYS-1:0][(DATA_W<<WSEL_W)-1:0] rd_line,
   input  logic                                    ww_en,
   input  logic [SET_W-1:0]                        ww_set,
   input  logic                                    ww_way,
   input  logic [WSEL_W-1:0]                       ww_idx,
   input  logic [DATA_W-1:0]                       ww_data,
   input  logic                                    lw_en,
   input  logic [SET_W-1:0]                        lw_set,
   input  logic                                    lw_way,
   input  logic [(DATA_W<<WSEL_W)-1:0]             lw_line
);
   localparam int unsigned NSETS     = 1 << SET_W;
   localparam int unsigned LINE_BITS = DATA_W << WSEL_W;

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic [LINE_BITS-1:0] line_q [NSETS];

      always_ff @(posedge clk) begin
         if (lw_en && (lw_way == 1'(w))) begin
            line_q[lw_set] <= lw_line;
         end else if (ww_en && (ww_way == 1'(w))) begin
            line_q[ww_set][ww_idx*DATA_W +: DATA_W] <= ww_data;
         end
      end

      assign rd_line[w] = line_q[rd_set];
   end
endmodule

// File: rtl/cache2w_wb_buf.sv
module cache2w_wb_buf #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned LINE_BITS = 128
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push,
   input  logic [ADDR_W-1:0]    push_addr,
   input  logic [LINE_BITS-1:0] push_line,
   input  logic                 ack,
   output logic                 full,
   output logic [ADDR_W-1:0]    addr,
   output logic [LINE_BITS-1:0] line
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         addr <= '0;
         line <= '0;
      end else if (push) begin
         full <= 1'b1;
         addr <= push_addr;
         line <= push_line;
      end else if (ack) begin
         full <= 1'b0;
      end
   end
endmodule

// File: rtl/cache2w_lookup.sv
module cache2w_lookup
   import cache2w_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned LINE_BYTES = 16,
   parameter int unsigned NUM_SETS   = 256
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic                          req_write,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [DATA_W-1:0]             req_wdata,
   output logic                          req_ready,
   output logic                          resp_valid,
   output logic                          resp_hit,
   output logic                          resp_way,
   output logic [DATA_W-1:0]             resp_rdata,
   output logic                          fill_req,
   output logic [ADDR_W-1:0]             fill_addr,
   input  logic                          fill_valid,
   input  logic [DATA_W-1:0]             fill_data,
   input  logic [1:0]                    fill_state,
   output logic                          wb_valid,
   output logic [ADDR_W-1:0]             wb_addr,
   output logic [LINE_BYTES*8-1:0]       wb_data,
   input  logic                          wb_ack,
   input  logic                          coh_upd,
   input  logic [$clog2(NUM_SETS)-1:0]   coh_set,
   input  logic                          coh_way,
   input  logic [1:0]                    coh_state
);
   localparam int unsigned OFF_W     = $clog2(LINE_BYTES);
   localparam int unsigned BSEL_W    = $clog2(DATA_W / 8);
   localparam int unsigned WORDS     = LINE_BYTES / (DATA_W / 8);
   localparam int unsigned WSEL_W    = $clog2(WORDS);
   localparam int unsigned SET_W     = $clog2(NUM_SETS);
   localparam int unsigned TAG_W     = ADDR_W - SET_W - OFF_W;
   localparam int unsigned LINE_BITS = LINE_BYTES * 8;
   localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if ((NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("NUM_SETS must be a power of two");
   end
   if ((DATA_W % 8) != 0 || WORDS < 2) begin : g_bad_word
      $error("DATA_W must be whole bytes and a line must hold at least two words");
   end
   if (ADDR_W <= SET_W + OFF_W) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end

   ctl_state_e             state_q;
   logic [ADDR_W-1:0]      miss_addr_q;
   logic                   miss_way_q;
   logic [WSEL_W-1:0]      beat_q;
   logic [LINE_BITS-1:0]   fill_buf_q;
   logic                   resp_valid_q, resp_hit_q, resp_way_q;
   logic [DATA_W-1:0]      resp_rdata_q;

   logic [SET_W-1:0]       req_set, miss_set, lk_set;
   logic [TAG_W-1:0]       req_tag;
   logic [WSEL_W-1:0]      req_widx, miss_widx;
   logic                   idle, accept;

   logic [NUM_WAYS-1:0]              lk_match;
   logic [NUM_WAYS-1:0][1:0]         lk_state;
   logic [NUM_WAYS-1:0][TAG_W-1:0]   lk_tagout;
   logic                             lk_lru;
   logic [NUM_WAYS-1:0][LINE_BITS-1:0] rd_line;

   logic                   hit_any, hit_way, victim_way, victim_dirty;
   logic [DATA_W-1:0]      hit_word;
   logic [LINE_BITS-1:0]   fill_line;
   logic                   last_beat, inst_en, touch_en, touch_way;
   logic [SET_W-1:0]       touch_set;
   logic                   ww_en, wb_push, wb_full;
   logic [ADDR_W-1:0]      wb_push_addr;

   assign req_set   = req_addr[OFF_W +: SET_W];
   assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];
   assign req_widx  = req_addr[BSEL_W +: WSEL_W];
   assign miss_set  = miss_addr_q[OFF_W +: SET_W];
   assign miss_widx = miss_addr_q[BSEL_W +: WSEL_W];

   assign idle   = (state_q == CS_IDLE);
   assign accept = idle && req_valid;
   assign lk_set = idle ? req_set : miss_set;

   cache2w_tag_dir #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_set     (lk_set),
      .lk_tag     (req_tag),
      .lk_match   (lk_match),
      .lk_state   (lk_state),
      .lk_tagout  (lk_tagout),
      .lk_lru     (lk_lru),
      .touch_en   (touch_en),
      .touch_set  (touch_set),
      .touch_way  (touch_way),
      .inst_en    (inst_en),
      .inst_set   (miss_set),
      .inst_way   (miss_way_q),
      .inst_tag   (miss_addr_q[ADDR_W-1 -: TAG_W]),
      .inst_state (fill_state),
      .coh_en     (coh_upd),
      .coh_set    (coh_set),
      .coh_way    (coh_way),
      .coh_state  (coh_state)
   );

   cache2w_data_ram #(.SET_W(SET_W), .WSEL_W(WSEL_W), .DATA_W(DATA_W)) u_data (
      .clk     (clk),
      .rd_set  (lk_set),
      .rd_line (rd_line),
      .ww_en   (ww_en),
      .ww_set  (req_set),
      .ww_way  (hit_way),
      .ww_idx  (req_widx),
      .ww_data (req_wdata),
      .lw_en   (inst_en),
      .lw_set  (miss_set),
      .lw_way  (miss_way_q),
      .lw_line (fill_line)
   );

   // way selection: way 1 wins only when it matches
   assign hit_any  = |lk_match;
   assign hit_way  = lk_match[1];
   assign hit_word = rd_line[hit_way][req_widx*DATA_W +: DATA_W];

   // victim: first Invalid way, else the LRU way
   always_comb begin
      if (lk_state[0] == LS_INV)      victim_way = 1'b0;
      else if (lk_state[1] == LS_INV) victim_way = 1'b1;
      else                            victim_way = lk_lru;
   end
   assign victim_dirty = (lk_state[victim_way] == LS_MOD);

   always_comb begin
      fill_line = fill_buf_q;
      fill_line[beat_q*DATA_W +: DATA_W] = fill_data;
   end

   assign last_beat = (state_q == CS_FILL) && fill_valid && (beat_q == LAST_BEAT);
   assign inst_en   = last_beat;
   assign ww_en     = accept && req_write && hit_any;
   assign touch_en  = (accept && hit_any) || inst_en;
   assign touch_set = idle ? req_set : miss_set;
   assign touch_way = idle ? hit_way : miss_way_q;

   assign wb_push      = (state_q == CS_DRAIN) && !wb_full;
   assign wb_push_addr = {lk_tagout[miss_way_q], miss_set, {OFF_W{1'b0}}};

   cache2w_wb_buf #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wb_push),
      .push_addr (wb_push_addr),
      .push_line (rd_line[miss_way_q]),
      .ack       (wb_ack),
      .full      (wb_full),
      .addr      (wb_addr),
      .line      (wb_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= CS_IDLE;
         miss_addr_q  <= '0;
         miss_way_q   <= 1'b0;
         beat_q       <= '0;
         fill_buf_q   <= '0;
         resp_valid_q <= 1'b0;
         resp_hit_q   <= 1'b0;
         resp_way_q   <= 1'b0;
         resp_rdata_q <= '0;
      end else begin
         resp_valid_q <= 1'b0;
         unique case (state_q)
            CS_IDLE: begin
               if (req_valid) begin
                  if (hit_any) begin
                     resp_valid_q <= 1'b1;
                     resp_hit_q   <= 1'b1;
                     resp_way_q   <= hit_way;
                     resp_rdata_q <= req_write ? req_wdata : hit_word;
                  end else if (req_write) begin
                     resp_valid_q <= 1'b1;
                     resp_hit_q   <= 1'b0;
                     resp_way_q   <= 1'b0;
                     resp_rdata_q <= '0;
                  end else begin
                     miss_addr_q <= req_addr;
                     miss_way_q  <= victim_way;
                     beat_q      <= '0;
                     state_q     <= victim_dirty ? CS_DRAIN : CS_FILL;
                  end
               end
            end
            CS_DRAIN: begin
               if (!wb_full) state_q <= CS_FILL;
            end
            CS_FILL: begin
               if (fill_valid) begin
                  fill_buf_q <= fill_line;
                  beat_q     <= beat_q + 1'b1;
                  if (beat_q == LAST_BEAT) begin
                     resp_valid_q <= 1'b1;
                     resp_hit_q   <= 1'b0;
                     resp_way_q   <= miss_way_q;
                     resp_rdata_q <= fill_line[miss_widx*DATA_W +: DATA_W];
                     state_q      <= CS_IDLE;
                  end
               end
            end
            default: state_q <= CS_IDLE;
         endcase
      end
   end

   assign req_ready  = idle;
   assign resp_valid = resp_valid_q;
   assign resp_hit   = resp_hit_q;
   assign resp_way   = resp_way_q;
   assign resp_rdata = resp_rdata_q;
   assign fill_req   = (state_q == CS_FILL);
   assign fill_addr  = {miss_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign wb_valid   = wb_full;
endmodule

// File: rtl/cache2w_lookup_chk.sv
module cache2w_lookup_chk #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned LINE_BITS = 128,
   parameter int unsigned OFF_W     = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_ready,
   input logic                 resp_valid,
   input logic                 resp_hit,
   input logic                 fill_req,
   input logic [ADDR_W-1:0]    fill_addr,
   input logic                 wb_valid,
   input logic [ADDR_W-1:0]    wb_addr,
   input logic [LINE_BITS-1:0] wb_data,
   input logic                 wb_ack
);
   AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |-> (fill_addr[OFF_W-1:0] == '0)); // R6

   AST_FILL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && $past(fill_req)) |-> $stable(fill_addr)); // R6

   AST_FILL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |-> !req_ready); // R6

   AST_FILL_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |-> !resp_valid); // R6

   AST_FILL_ENDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fill_req) |-> (resp_valid && !resp_hit)); // R6

   AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_hit) |-> $past(req_valid && req_ready)); // R2

   AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ack) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data))); // R9

   AST_WB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_addr[OFF_W-1:0] == '0)); // R9
endmodule

bind cache2w_lookup cache2w_lookup_chk #(
   .ADDR_W    (ADDR_W),
   .LINE_BITS (LINE_BITS),
   .OFF_W     (OFF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .resp_valid (resp_valid),
   .resp_hit   (resp_hit),
   .fill_req   (fill_req),
   .fill_addr  (fill_addr),
   .wb_valid   (wb_valid),
   .wb_addr    (wb_addr),
   .wb_data    (wb_data),
   .wb_ack     (wb_ack)
);

// File: tb/cache2w_lookup_tb.sv
module cache2w_lookup_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0, req_write = 1'b0;
   logic [31:0]  req_addr = '0, req_wdata = '0;
   logic         req_ready, resp_valid, resp_hit, resp_way;
   logic [31:0]  resp_rdata;
   logic         fill_req;
   logic [31:0]  fill_addr;
   logic         fill_valid = 1'b0;
   logic [31:0]  fill_data = '0;
   logic [1:0]   fill_state = 2'b10;
   logic         wb_valid;
   logic [31:0]  wb_addr;
   logic [127:0] wb_data;
   logic         wb_ack = 1'b0;
   logic         coh_upd = 1'b0;
   logic [7:0]   coh_set = '0;
   logic         coh_way = 1'b0;
   logic [1:0]   coh_state = '0;

   int n_cmp = 0;
   int n_bad = 0;
   int beat = 0;

   always #10 clk = ~clk; // 50 MHz

   cache2w_lookup dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
      .resp_rdata(resp_rdata), .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid),
      .fill_data(fill_data), .fill_state(fill_state), .wb_valid(wb_valid), .wb_addr(wb_addr),
      .wb_data(wb_data), .wb_ack(wb_ack), .coh_upd(coh_upd), .coh_set(coh_set),
      .coh_way(coh_way), .coh_state(coh_state)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      logic [31:0] w;
      w = {a[31:2], 2'b00};
      return {w[15:0] ^ 16'h5A3C, w[15:0] + 16'h1111};
   endfunction

   task automatic check(input string rq, input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // memory model: answers fills one word per cycle, words 0..3
   initial begin
      forever begin
         @(negedge clk);
         if (fill_req && beat < 4) begin
            fill_valid = 1'b1;
            fill_data  = mem_word(fill_addr + 32'(4 * beat));
            beat++;
         end else begin
            fill_valid = 1'b0;
            if (!fill_req) beat = 0;
         end
      end
   end

   task automatic run_req(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          output logic hit, output logic way, output logic [31:0] rd, output int lat);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!resp_valid && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      hit = resp_hit; way = resp_way; rd = resp_rdata;
   endtask

   task automatic set_state(input logic [7:0] s, input logic w, input logic [1:0] st);
      @(negedge clk);
      coh_upd = 1'b1; coh_set = s; coh_way = w; coh_state = st;
      @(negedge clk);
      coh_upd = 1'b0;
   endtask

   typedef struct packed {
      logic        wr;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic        use_mem;
      logic [31:0] exp_data;
      logic        exp_hit;
      logic        exp_way;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 32'h0000_1234, 32'h0,          1'b1, 32'h0,          1'b0, 1'b0}, // R6 cold miss
      '{1'b0, 32'h0000_1230, 32'h0,          1'b1, 32'h0,          1'b1, 1'b0}, // R2 hit word 0
      '{1'b0, 32'h0000_2234, 32'h0,          1'b1, 32'h0,          1'b0, 1'b1}, // R5 free way 1
      '{1'b0, 32'h0000_1238, 32'h0,          1'b1, 32'h0,          1'b1, 1'b0}, // R3 both resident
      '{1'b0, 32'h0000_223C, 32'h0,          1'b1, 32'h0,          1'b1, 1'b1}, // R3 way 1 hit
      '{1'b1, 32'h0000_1234, 32'hDEAD_BEEF,  1'b0, 32'hDEAD_BEEF,  1'b1, 1'b0}, // R7 write hit
      '{1'b0, 32'h0000_1237, 32'h0,          1'b0, 32'hDEAD_BEEF,  1'b1, 1'b0}, // R1 byte bits ignored
      '{1'b0, 32'h0000_1238, 32'h0,          1'b1, 32'h0,          1'b1, 1'b0}, // R7 neighbour intact
      '{1'b1, 32'h0000_5000, 32'h1111_2222,  1'b0, 32'h0,          1'b0, 1'b0}, // R7 write miss
      '{1'b0, 32'h0000_5000, 32'h0,          1'b1, 32'h0,          1'b0, 1'b0}, // R7 no allocation
      '{1'b0, 32'h0000_3230, 32'h0,          1'b1, 32'h0,          1'b0, 1'b1}, // R4 LRU victim
      '{1'b0, 32'h0000_1230, 32'h0,          1'b1, 32'h0,          1'b1, 1'b0}, // R4 survivor
      '{1'b0, 32'h0000_2234, 32'h0,          1'b1, 32'h0,          1'b0, 1'b1}, // R4 evicted
      '{1'b0, 32'h0000_1234, 32'h0,          1'b0, 32'hDEAD_BEEF,  1'b1, 1'b0}  // R4 way 0 kept
   };
   string vreq [NV] = '{"R6", "R2", "R5", "R3", "R3", "R7", "R1",
                        "R7", "R7", "R7", "R4", "R4", "R4", "R4"};

   initial begin
      #(20 * 100000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic        h, w;
      logic [31:0] rd, expd;
      int          lat;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 ready", req_ready, 1);
      check("R11 resp_valid", resp_valid, 0);
      check("R11 fill_req", fill_req, 0);
      check("R11 wb_valid", wb_valid, 0);

      for (int i = 0; i < NV; i++) begin
         run_req(VECS[i].wr, VECS[i].addr, VECS[i].wdata, h, w, rd, lat);
         expd = VECS[i].use_mem ? mem_word(VECS[i].addr) : VECS[i].exp_data;
         check({vreq[i], " hit"}, h, VECS[i].exp_hit);
         check({vreq[i], " way"}, w, VECS[i].exp_way);
         if (!VECS[i].wr || VECS[i].exp_hit) check({vreq[i], " data"}, rd, expd);
         check({vreq[i], " latency"}, lat, (VECS[i].exp_hit || VECS[i].wr) ? 1 : 5);
      end
      check("R9 no write-back from clean lines", wb_valid, 0);

      // R8: invalidate way 0 of set 0x23; R5: the Invalid way is refilled although LRU names way 1
      set_state(8'h23, 1'b0, 2'b00);
      run_req(1'b0, 32'h0000_1234, 32'h0, h, w, rd, lat);
      check("R8 invalid line misses", h, 0);
      check("R5 invalid way preferred", w, 0);
      check("R8 refetched word", rd, mem_word(32'h0000_1234));
      check("R6 fill address", fill_addr, 32'h0000_1230);

      // R9: mark way 0 Modified, steer LRU to it, then force its eviction
      set_state(8'h23, 1'b0, 2'b11);
      run_req(1'b0, 32'h0000_2234, 32'h0, h, w, rd, lat);
      check("R4 touch way 1", h, 1);
      run_req(1'b0, 32'h0000_4230, 32'h0, h, w, rd, lat);
      check("R9 miss data", rd, mem_word(32'h0000_4230));
      check("R9 victim way", w, 0);
      check("R9 drain adds a cycle", lat, 6);
      check("R9 wb_valid", wb_valid, 1);
      check("R9 wb_addr", wb_addr, 32'h0000_1230);
      check("R9 wb_data", wb_data, {mem_word(32'h123C), mem_word(32'h1238),
                                    mem_word(32'h1234), mem_word(32'h1230)});

      // R10: second Modified victim while the buffer is still occupied
      set_state(8'h23, 1'b1, 2'b11);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_6230;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (6) @(negedge clk);
      check("R10 fill held", fill_req, 0);
      check("R10 requests held", req_ready, 0);
      check("R9 buffer unchanged", wb_addr, 32'h0000_1230);
      wb_ack = 1'b1;
      @(negedge clk);
      wb_ack = 1'b0;
      lat = 0;
      while (!resp_valid && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      check("R10 miss data", resp_rdata, mem_word(32'h0000_6230));
      check("R10 miss way", resp_way, 1);
      check("R10 hit low", resp_hit, 0);
      check("R10 new buffered line", wb_addr, 32'h0000_2230);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule